// File: doc/BRIEF.md
# Serial Divider Program Register

This block receives the main-divider setting of a frequency synthesizer over a three-wire serial port: a data line, a shift clock and a load-enable. It oversamples the three lines on a fast local clock and detects each rising edge of the shift clock. On every detected edge, one data bit enters a 14-bit shift register. While load-enable is high, the holding register follows the shift register. While it is low, the holding register keeps its last value.

The held word is split into a 9-bit program count and a 5-bit swallow count, and both go to the divider. The program count is sent first, most significant bit leading, and the swallow count follows, so its least significant bit is the last bit shifted. A program count below 32 is passed through unchanged, and a flag output marks it as out of range. After reset, the outputs carry a legal default of program count 32 and swallow count 0.

Top module: `divprog_serial_reg`

## Requirements
- R1: A synchronous active-low reset clears the shift register to all zeros and sets the outputs to program count 32, swallow count 0 and out-of-range flag 0.
- R2: Each rising edge of the shift clock moves exactly one data bit into the shift register. The data bit is taken at the same sample as the clock edge.
- R3: After 14 shifts, the first bit shifted is bit 8 (the MSB) of the program count and the ninth bit is bit 0 of the program count. The tenth bit is bit 4 of the swallow count and the fourteenth bit is bit 0 of the swallow count. In word terms, the program count is word[13:5] and the swallow count is word[4:0].
- R4: While load-enable is high, the outputs show the shift register contents no later than 3 local clock cycles after load-enable rises.
- R5: While load-enable is low, the outputs do not change, whatever activity occurs on the data line and the shift clock.
- R6: While load-enable stays high, each new shift is visible at the outputs within 4 local clock cycles of the shift clock edge.
- R7: The out-of-range flag is 1 exactly when the program count output is below 32. The program count is presented unchanged in that case.
- R8: If more than 14 bits are shifted before a load, only the last 14 bits are kept.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Local oversampling clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ser_data | input | 1 | Serial data line |
| ser_clk | input | 1 | Serial shift clock; shifting happens on its rising edge |
| load_en | input | 1 | Level-sensitive load-enable for the holding register |
| prog_cnt | output | 9 | Held program count |
| swal_cnt | output | 5 | Held swallow count |
| prog_low | output | 1 | High when prog_cnt is below 32 |

## Verification
A shift and a holding-register transfer can fall in the same local clock cycle when load-enable is kept high while the shift clock toggles. The bench provokes this by shifting bits one at a time with load-enable held high. After each shift it compares the outputs with the arithmetically predicted word, formed as the previous word shifted left with the new bit appended. The rest of the bench sweeps every program count from 0 to 511 and every swallow count, loaded in the normal way. Each loaded word is checked field by field and against the range flag.

// File: rtl/divprog_pkg.sv
`timescale 1ns/1ps
// Package: divprog_pkg
// Shared widths and defaults for the serial divider program register.
// Assumes the program count is sent before the swallow count, MSB first.
package divprog_pkg;
    localparam int unsigned PROG_W  = 9;
    localparam int unsigned SWAL_W  = 5;
    localparam int unsigned WORD_W  = PROG_W + SWAL_W;
    localparam int unsigned PROG_MIN = 32;
    localparam int unsigned PROG_RST = 32;
    localparam int unsigned SWAL_RST = 0;

    typedef struct packed {
        logic [PROG_W-1:0] prog;
        logic [SWAL_W-1:0] swal;
    } div_word_t;
endpackage

// File: rtl/divprog_sampler.sv
`timescale 1ns/1ps
// Module: divprog_sampler
// Registers the serial data, shift clock and load-enable on the local clock,
// and produces a one-cycle pulse for each rising edge of the shift clock.
// Assumes the serial lines are slow compared with clk (microsecond timing).
module divprog_sampler (
    input  logic clk,
    input  logic rst_n,
    input  logic ser_data,
    input  logic ser_clk,
    input  logic load_en,
    output logic bit_q,
    output logic shift_pulse,
    output logic load_q
);
    logic sclk_q;
    logic sclk_prev;

    // Sample the serial lines and keep one cycle of shift-clock history.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sclk_q    <= 1'b0;
            sclk_prev <= 1'b0;
            bit_q     <= 1'b0;
            load_q    <= 1'b0;
        end else begin
            sclk_q    <= ser_clk;
            sclk_prev <= sclk_q;
            bit_q     <= ser_data;
            load_q    <= load_en;
        end
    end

    // Rising-edge detection on the sampled shift clock.
    always_comb begin
        shift_pulse = sclk_q & ~sclk_prev;
    end

    // R2
    pulse_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        shift_pulse |=> !shift_pulse);
endmodule

// File: rtl/divprog_shifter.sv
`timescale 1ns/1ps
// Module: divprog_shifter
// A shift register of WIDTH bits. On each shift pulse the word moves up one
// place and the new bit enters at bit 0, so the first bit sent ends up at the MSB.
// Assumes shift_pulse lasts a single cycle per serial clock edge.
module divprog_shifter #(
    parameter int unsigned WIDTH = divprog_pkg::WORD_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             shift_pulse,
    input  logic             bit_in,
    output logic [WIDTH-1:0] word
);
    // Clear on reset; move one place up per shift pulse.
    always_ff @(posedge clk) begin
        if (!rst_n)
            word <= '0;
        else if (shift_pulse)
            word <= {word[WIDTH-2:0], bit_in};
    end

    // R2
    idle_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !shift_pulse |=> $stable(word));
endmodule

// File: rtl/divprog_hold.sv
`timescale 1ns/1ps
// Module: divprog_hold
// Holding register that follows the shift register on every cycle the sampled
// load-enable is high (level-sensitive transfer) and keeps its value otherwise.
// Assumes the reset word is a legal divider setting.
module divprog_hold #(
    parameter int unsigned WIDTH   = divprog_pkg::WORD_W,
    parameter logic [WIDTH-1:0] RST_WORD = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load_q,
    input  logic [WIDTH-1:0] shreg,
    output logic [WIDTH-1:0] held
);
    // Load the default on reset; follow the shift register while enabled.
    always_ff @(posedge clk) begin
        if (!rst_n)
            held <= RST_WORD;
        else if (load_q)
            held <= shreg;
    end

    // R4
    load_copy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        load_q |=> (held == $past(shreg)));

    // R5
    hold_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !load_q |=> $stable(held));
endmodule

// File: rtl/divprog_serial_reg.sv
`timescale 1ns/1ps
// Module: divprog_serial_reg
// Top of the serial divider program register: sampler, shift register,
// holding register and field split with a range flag on the program count.
// Assumes ser_clk, ser_data and load_en each stay stable for several clk cycles.
module divprog_serial_reg #(
    parameter int unsigned PROG_W   = divprog_pkg::PROG_W,
    parameter int unsigned SWAL_W   = divprog_pkg::SWAL_W,
    parameter int unsigned PROG_MIN = divprog_pkg::PROG_MIN,
    parameter int unsigned PROG_RST = divprog_pkg::PROG_RST,
    parameter int unsigned SWAL_RST = divprog_pkg::SWAL_RST
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ser_data,
    input  logic              ser_clk,
    input  logic              load_en,
    output logic [PROG_W-1:0] prog_cnt,
    output logic [SWAL_W-1:0] swal_cnt,
    output logic              prog_low
);
    localparam int unsigned WORD_W = PROG_W + SWAL_W;
    localparam logic [WORD_W-1:0] RST_WORD =
        {PROG_W'(PROG_RST), SWAL_W'(SWAL_RST)};

    logic              bit_q;
    logic              shift_pulse;
    logic              load_q;
    logic [WORD_W-1:0] shreg;
    logic [WORD_W-1:0] held;

    divprog_sampler u_sampler (
        .clk        (clk),
        .rst_n      (rst_n),
        .ser_data   (ser_data),
        .ser_clk    (ser_clk),
        .load_en    (load_en),
        .bit_q      (bit_q),
        .shift_pulse(shift_pulse),
        .load_q     (load_q)
    );

    divprog_shifter #(.WIDTH(WORD_W)) u_shifter (
        .clk        (clk),
        .rst_n      (rst_n),
        .shift_pulse(shift_pulse),
        .bit_in     (bit_q),
        .word       (shreg)
    );

    divprog_hold #(.WIDTH(WORD_W), .RST_WORD(RST_WORD)) u_hold (
        .clk   (clk),
        .rst_n (rst_n),
        .load_q(load_q),
        .shreg (shreg),
        .held  (held)
    );

    // Split the held word: program count in the upper bits, swallow below.
    always_comb begin
        prog_cnt = held[WORD_W-1:SWAL_W];
        swal_cnt = held[SWAL_W-1:0];
        prog_low = (32'(prog_cnt) < PROG_MIN);
    end

    // R1
    reset_value_chk: assert property (@(posedge clk)
        !rst_n |=> (32'(prog_cnt) == PROG_RST && 32'(swal_cnt) == SWAL_RST && !prog_low));
endmodule

// File: tb/divprog_serial_reg_tb_top.sv
`timescale 1ns/1ps
module divprog_serial_reg_tb_top;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic ser_data = 1'b0;
    logic ser_clk = 1'b0;
    logic load_en = 1'b0;
    logic [8:0] prog_cnt;
    logic [4:0] swal_cnt;
    logic prog_low;

    int n_cmp = 0;
    int n_bad = 0;
    logic [13:0] exp_word;

    always #5 clk = ~clk;

    divprog_serial_reg dut_i (
        .clk(clk), .rst_n(rst_n), .ser_data(ser_data), .ser_clk(ser_clk),
        .load_en(load_en), .prog_cnt(prog_cnt), .swal_cnt(swal_cnt),
        .prog_low(prog_low)
    );

    task automatic wait_clk(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic chk(input string tag, input int act, input int expv);
        n_cmp++;
        if (act != expv) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, expv);
        end
    endtask

    task automatic chk_word(input string tag, input logic [13:0] w);
        chk({tag, " prog"}, int'(prog_cnt), int'(w[13:5]));
        chk({tag, " swal"}, int'(swal_cnt), int'(w[4:0]));
        chk({tag, " R7 flag"}, int'(prog_low), (w[13:5] < 9'd32) ? 1 : 0);
    endtask

    task automatic shift_bit(input logic b);
        ser_data = b;
        wait_clk(4);
        ser_clk = 1'b1;
        wait_clk(4);
        ser_clk = 1'b0;
    endtask

    task automatic shift_word(input logic [13:0] w);
        for (int i = 13; i >= 0; i--) shift_bit(w[i]);
    endtask

    task automatic pulse_load();
        load_en = 1'b1;
        wait_clk(4);
        load_en = 1'b0;
        wait_clk(4);
    endtask

    initial begin
        #(200000 * 10);
        n_bad++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        wait_clk(4);
        rst_n = 1'b1;
        wait_clk(2);
        // R1: default outputs
        chk("R1 reset prog", int'(prog_cnt), 32);
        chk("R1 reset swal", int'(swal_cnt), 0);
        chk("R1 reset flag", int'(prog_low), 0);
        // R1: shift register cleared, visible by loading without shifting
        pulse_load();
        chk_word("R1 cleared shreg", 14'd0);

        // R3: field order with a distinctive word
        exp_word = {9'b100000001, 5'b10011};
        shift_word(exp_word);
        pulse_load();
        chk_word("R3 order", exp_word);

        // R5: shifting with load low leaves outputs alone
        shift_word(14'h2AAA);
        wait_clk(4);
        chk_word("R5 hold while low", exp_word);

        // R4: latency of transfer after load_en rises
        load_en = 1'b1;
        wait_clk(3);
        chk_word("R4 transfer", 14'h2AAA);
        load_en = 1'b0;
        wait_clk(4);

        // R6 / R2: shifting while load_en held high, one bit at a time
        exp_word = 14'h2AAA;
        load_en = 1'b1;
        wait_clk(4);
        for (int i = 0; i < 20; i++) begin
            logic b;
            b = ((i * 5 + 1) % 3) == 0;
            shift_bit(b);
            exp_word = {exp_word[12:0], b};
            chk_word("R6 R2 transparent shift", exp_word);
        end
        load_en = 1'b0;
        wait_clk(4);

        // R8: more than 14 bits, last 14 kept
        shift_word(14'h3FFF);
        shift_word(14'h1234);
        pulse_load();
        chk_word("R8 overlong", 14'h1234);

        // R3 R7: full program count sweep
        for (int n = 0; n < 512; n++) begin
            logic [13:0] w;
            w = {9'(n), 5'((n * 7 + 3) % 32)};
            shift_word(w);
            pulse_load();
            chk_word("R3 R7 sweep", w);
        end
        // R3: full swallow count sweep
        for (int a = 0; a < 32; a++) begin
            logic [13:0] w;
            w = {9'(300 + a), 5'(a)};
            shift_word(w);
            pulse_load();
            chk_word("R3 swal sweep", w);
        end

        // R1: reset mid-run restores defaults
        rst_n = 1'b0;
        wait_clk(2);
        rst_n = 1'b1;
        wait_clk(1);
        chk_word("R1 rerun", {9'd32, 5'd0});

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule